// File: doc/BRIEF.md
# Serial Control and Status Port

This block is the host-facing serial port of a telephony modem core. A host drives a serial clock, an enable strobe and a read/write select, and it shares one data line with the block. In the write direction the host shifts a 16-bit control word into a shift register. While enable is high, that word drives the mode control outputs of the modem. When enable is low, those outputs keep their last value.

In the read direction the block drives the data line. A rising edge of enable copies a 4-bit received tone code into a small status shifter, and bit 0 of the code appears at once. Each serial clock rise then moves the next bit out. A holding register sits between the tone decoder and the status shifter. It captures the decoder's code on the falling edge of an active-low data-valid signal. The port also gates the demodulated receive bit with an active-low carrier-detect input.

All pin inputs cross into one system clock domain through two-flop synchronizers. Edges are found by comparing each synchronized level with a registered copy of it. A pin change therefore acts on the third system clock edge after it.

Top module: `modem_ctrl_port`

## Requirements
- R1: While `rw_i` is low, each serial clock rise shifts `data_i` into the 16-bit control register MSB first, so the first bit sent ends in bit 15. While `rw_i` is high, the control register does not change.
- R2: While `en_i` is low, `mode_o` holds its value whatever is shifted into the control register.
- R3: While `en_i` is high and `rw_i` is low, `mode_o` follows the control register contents.
- R4: A serial clock rise with `rw_i` low and `en_i` high sets `proto_err_o`. The flag stays set until reset, and `mode_o` does not change in that cycle.
- R5: With `rw_i` high, a rising edge of `en_i` copies the holding register into the 4-bit status register, and its bit 0 appears on `data_o` before any serial clock edge.
- R6: With `rw_i` high, each serial clock rise shifts the status register toward bit 0, so the code leaves LSB first. After the four code bits, `data_o` is 0.
- R7: `data_oe_o` is the synchronized `rw_i` delayed by one system clock. It falls on the third system clock edge after the pin falls.
- R8: The holding register loads `tone_i` only on a falling edge of `dv_n_i`. Changes of `tone_i` at other times have no effect.
- R9: `rxd_o` is 1 while `cd_n_i` is high, and it equals `demod_i` while `cd_n_i` is low. Its value after reset is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| en_i | input | 1 | Enable strobe: apply control word (write) or load status (read) |
| rw_i | input | 1 | Direction select: 0 write, 1 read |
| data_i | input | 1 | Data line value driven by the host |
| data_o | output | 1 | Data line value driven by the block (status bit 0) |
| data_oe_o | output | 1 | Output enable for the shared data line |
| dv_n_i | input | 1 | Active-low tone data-valid from the decoder |
| tone_i | input | 4 | Decoded tone code from the decoder |
| cd_n_i | input | 1 | Active-low carrier detect |
| demod_i | input | 1 | Demodulated receive bit |
| rxd_o | output | 1 | Gated receive data |
| mode_o | output | 16 | Mode control word applied to the modem |
| proto_err_o | output | 1 | Sticky flag for a shift while enable is high |

## Verification
The write path is tried with a walking one across all 16 bits and with 16'h8001, 16'hA5C3, all-ones and all-zeros. The walking one catches any reversed or shifted bit order. The mixed words catch stuck or swapped bits. Each word is checked both before enable and after it, which separates isolation from application. The read path is swept over all 16 tone codes, with five serial clocks per code. The fifth shift shows zero fill. Between the data-valid edge and the read, the tone input is changed to the inverted code, and the old code must still come out. Carrier gating is checked with the demodulator held at both values while carrier is present and while it is absent.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
    localparam int CTRL_W      = 16;
    localparam int STAT_W      = 4;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_evt_t;

    function automatic pin_evt_t mk_evt(input logic cur, input logic prev);
        pin_evt_t e;
        e.lvl  = cur;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction
endpackage

// File: rtl/mcp_sync.sv
module mcp_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
            prev_o <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            prev_o <= chain[STAGES-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl #(
    parameter int W = mcp_pkg::CTRL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         bit_i,
    input  logic         en_i,
    input  logic         rw_i,
    output logic [W-1:0] ctrl_o,
    output logic [W-1:0] mode_o,
    output logic         err_o
);
    logic apply;
    assign apply = en_i && !rw_i && !shift_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            mode_o <= '0;
            err_o  <= 1'b0;
        end else begin
            if (shift_i) ctrl_o <= {ctrl_o[W-2:0], bit_i};
            if (apply) mode_o <= ctrl_o;
            if (shift_i && en_i) err_o <= 1'b1;
        end
    end
endmodule

// File: rtl/mcp_stat.sv
module mcp_stat #(
    parameter int W = mcp_pkg::STAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture_i,
    input  logic [W-1:0] code_i,
    input  logic         load_i,
    input  logic         shift_i,
    output logic [W-1:0] hold_o,
    output logic [W-1:0] stat_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_o <= '0;
            stat_o <= '0;
        end else begin
            if (capture_i) hold_o <= code_i;
            if (load_i)        stat_o <= hold_o;
            else if (shift_i)  stat_o <= {1'b0, stat_o[W-1:1]};
        end
    end
endmodule

// File: rtl/modem_ctrl_port.sv
module modem_ctrl_port
    import mcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              en_i,
    input  logic              rw_i,
    input  logic              data_i,
    output logic              data_o,
    output logic              data_oe_o,
    input  logic              dv_n_i,
    input  logic [STAT_W-1:0] tone_i,
    input  logic              cd_n_i,
    input  logic              demod_i,
    output logic              rxd_o,
    output logic [CTRL_W-1:0] mode_o,
    output logic              proto_err_o
);
    localparam int NPIN = 7;
    localparam logic [NPIN-1:0] PIN_RST = 7'b0110000;

    // pin bundle: {dv_n, cd_n, demod, data, rw, en, sclk}
    logic [NPIN-1:0] pins, pins_q, pins_p;
    logic [STAT_W-1:0] tone_q, tone_p;

    assign pins = {dv_n_i, cd_n_i, demod_i, data_i, rw_i, en_i, sclk_i};

    mcp_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_pin_sync (
        .clk(clk), .rst(rst), .d_i(pins), .q_o(pins_q), .prev_o(pins_p)
    );

    mcp_sync #(.W(STAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_tone_sync (
        .clk(clk), .rst(rst), .d_i(tone_i), .q_o(tone_q), .prev_o(tone_p)
    );

    pin_evt_t sclk_e, en_e, dv_e;
    logic rw_s, din_s, demod_s, cd_s;
    always_comb begin
        sclk_e  = mk_evt(pins_q[0], pins_p[0]);
        en_e    = mk_evt(pins_q[1], pins_p[1]);
        dv_e    = mk_evt(pins_q[6], pins_p[6]);
        rw_s    = pins_q[2];
        din_s   = pins_q[3];
        demod_s = pins_q[4];
        cd_s    = pins_q[5];
    end

    logic sclk_rise, en_rise, dv_fall, wr_shift, rd_shift, rd_load;
    assign sclk_rise = sclk_e.rise;
    assign en_rise   = en_e.rise;
    assign dv_fall   = dv_e.fall;
    assign wr_shift  = sclk_rise && !rw_s;
    assign rd_shift  = sclk_rise && rw_s;
    assign rd_load   = en_rise && rw_s;

    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] hold_q, stat_q;

    mcp_ctrl #(.W(CTRL_W)) u_ctrl (
        .clk(clk), .rst(rst), .shift_i(wr_shift), .bit_i(din_s),
        .en_i(en_e.lvl), .rw_i(rw_s),
        .ctrl_o(ctrl_q), .mode_o(mode_o), .err_o(proto_err_o)
    );

    mcp_stat #(.W(STAT_W)) u_stat (
        .clk(clk), .rst(rst), .capture_i(dv_fall), .code_i(tone_q),
        .load_i(rd_load), .shift_i(rd_shift),
        .hold_o(hold_q), .stat_o(stat_q)
    );

    assign data_o = stat_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_oe_o <= 1'b0;
            rxd_o     <= 1'b1;
        end else begin
            data_oe_o <= rw_s;
            rxd_o     <= cd_s ? 1'b1 : demod_s;
        end
    end
endmodule

// File: rtl/mcp_checker.sv
module mcp_checker (
    input logic        clk,
    input logic        rst,
    input logic        sclk_rise,
    input logic        en_rise,
    input logic        en_s,
    input logic        rw_s,
    input logic        din_s,
    input logic        cd_s,
    input logic [15:0] ctrl_q,
    input logic [3:0]  hold_q,
    input logic [3:0]  stat_q,
    input logic [15:0] mode_o,
    input logic        proto_err_o,
    input logic        data_oe_o,
    input logic        rxd_o
);
    a_r1_shift_msb_first: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && !rw_s) |=> ctrl_q == {$past(ctrl_q[14:0]), $past(din_s)});

    a_r1_read_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
        rw_s |=> $stable(ctrl_q));

    a_r2_isolated: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> $stable(mode_o));

    a_r4_err_sets: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && !rw_s && en_s) |=> (proto_err_o && $stable(mode_o)));

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |=> proto_err_o);

    a_r5_status_load: assert property (@(posedge clk) disable iff (rst)
        (en_rise && rw_s) |=> stat_q == $past(hold_q));

    a_r7_oe_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> data_oe_o == $past(rw_s));

    a_r9_rxd_clamp: assert property (@(posedge clk) disable iff (rst)
        cd_s |=> rxd_o);
endmodule

bind modem_ctrl_port mcp_checker u_chk (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .en_rise(en_rise),
    .en_s(en_e.lvl), .rw_s(rw_s), .din_s(din_s), .cd_s(cd_s),
    .ctrl_q(ctrl_q), .hold_q(hold_q), .stat_q(stat_q), .mode_o(mode_o),
    .proto_err_o(proto_err_o), .data_oe_o(data_oe_o), .rxd_o(rxd_o)
);

// File: tb/modem_ctrl_port_test.sv
module modem_ctrl_port_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, en = 1'b0, rw = 1'b0, din = 1'b0;
    logic dv_n = 1'b1, cd_n = 1'b1, demod = 1'b0;
    logic [3:0] tone = 4'h0;
    logic data_o, data_oe, rxd, perr;
    logic [15:0] mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    modem_ctrl_port uut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .en_i(en), .rw_i(rw),
        .data_i(din), .data_o(data_o), .data_oe_o(data_oe),
        .dv_n_i(dv_n), .tone_i(tone), .cd_n_i(cd_n), .demod_i(demod),
        .rxd_o(rxd), .mode_o(mode), .proto_err_o(perr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sclk();
        sclk = 1'b1; idle(5);
        sclk = 1'b0; idle(5);
    endtask

    task automatic send_bit(input logic b);
        din = b; idle(4);
        pulse_sclk();
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    logic [15:0] applied;
    logic [15:0] words [20];

    initial begin
        idle(3);
        rst = 1'b0;
        idle(5);
        check("R2 reset mode", 32'(mode), 32'h0);
        check("R4 reset err", 32'(perr), 32'h0);
        check("R7 reset oe", 32'(data_oe), 32'h0);
        check("R9 reset rxd", 32'(rxd), 32'h1);

        // R9: carrier gating
        demod = 1'b0; idle(5);
        check("R9 no carrier demod0", 32'(rxd), 32'h1);
        cd_n = 1'b0; idle(5);
        check("R9 carrier demod0", 32'(rxd), 32'h0);
        demod = 1'b1; idle(5);
        check("R9 carrier demod1", 32'(rxd), 32'h1);
        demod = 1'b0; cd_n = 1'b1; idle(5);
        check("R9 carrier lost", 32'(rxd), 32'h1);

        // R1/R2/R3: write sweep
        for (int i = 0; i < 16; i++) words[i] = 16'(1) << i;
        words[16] = 16'h8001; words[17] = 16'hA5C3;
        words[18] = 16'hFFFF; words[19] = 16'h0000;
        applied = 16'h0;
        for (int k = 0; k < 20; k++) begin
            send_word(words[k]);
            check("R2 hold before enable", 32'(mode), 32'(applied));
            en = 1'b1; idle(6);
            check("R1 R3 applied word", 32'(mode), 32'(words[k]));
            en = 1'b0; idle(4);
            applied = words[k];
        end
        check("R4 no error in clean writes", 32'(perr), 32'h0);

        // R4: shift with enable high
        send_word(16'h1234);
        en = 1'b1; idle(6);
        check("R3 follow 1234", 32'(mode), 32'h1234);
        send_bit(1'b1);
        check("R4 err set", 32'(perr), 32'h1);
        check("R3 follows after shift", 32'(mode), 32'h2469);
        en = 1'b0; idle(10);
        check("R4 err sticky", 32'(perr), 32'h1);
        applied = 16'h2469;

        // R5/R6/R7/R8: read sweep over all codes
        for (int c = 0; c < 16; c++) begin
            tone = 4'(c); idle(4);
            dv_n = 1'b0; idle(5);
            dv_n = 1'b1; idle(2);
            tone = ~4'(c); idle(5);
            rw = 1'b1; idle(5);
            check("R7 oe on read", 32'(data_oe), 32'h1);
            en = 1'b1; idle(5);
            check("R5 D0 after load", 32'(data_o), 32'(c & 1));
            check("R2 mode kept during read", 32'(mode), 32'(applied));
            en = 1'b0; idle(4);
            for (int k = 1; k <= 5; k++) begin
                sclk = 1'b1; idle(5);
                check("R6 shifted bit", 32'(data_o), (k < 4) ? 32'((c >> k) & 1) : 32'h0);
                sclk = 1'b0; idle(5);
            end
            rw = 1'b0;
            @(posedge clk); @(posedge clk); #1;
            check("R7 oe still high", 32'(data_oe), 32'h1);
            @(posedge clk); #1;
            check("R7 oe low", 32'(data_oe), 32'h0);
            idle(4);
        end

        // R8: tone change without data-valid edge is ignored
        tone = 4'hA; idle(4);
        dv_n = 1'b0; idle(5); dv_n = 1'b1; idle(4);
        tone = 4'h5; idle(8);
        rw = 1'b1; idle(5);
        en = 1'b1; idle(5); en = 1'b0; idle(4);
        check("R8 D0 of held code", 32'(data_o), 32'h0);
        pulse_sclk();
        check("R8 D1 of held code", 32'(data_o), 32'h1);
        rw = 1'b0; idle(5);

        // R1: reads left control register intact
        en = 1'b1; idle(6);
        check("R1 ctrl kept across reads", 32'(mode), 32'(applied));
        en = 1'b0; idle(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule